// File: doc/BRIEF.md
# Performance-Bounded Voltage Level Selector

This block chooses how far the supply of a DRAM cell array can be lowered without costing any running program more performance than a user-set bound. It receives a table of candidate supply levels. Index 0 is the nominal, highest level, and each higher index is a lower voltage with a longer access latency. The table spans from nominal (1.35 V) down to 1.0 V. For each candidate it predicts the loss of every application with a signed fixed-point linear model. The model's inputs are the candidate's latency, the application's memory intensity (last-level cache misses per thousand instructions) and its memory stall time. A level is accepted only when every application's prediction stays within the bound.

A one-cycle start pulse launches a scan. The control state machine has three states. IDLE waits for start and moves to EVAL on it. EVAL holds one application of one candidate per cycle and has three transitions:
- "advance": it stays in EVAL and moves to the next application, or to the next lower level once all applications have passed.
- "reject": it goes to DONE when an application fails.
- "exhaust": it goes to DONE when the last application of the lowest level passes.

DONE raises the done strobe for one cycle and always returns to IDLE. The scan stops at the first failing level, because lower levels only lengthen latency. If the first lowered level already fails, the nominal level is kept. The coefficients, the table and the statistics must stay stable while a scan runs.

Top module: `perf_volt_sel`

## Requirements
- R1: While reset is asserted and after its release, `done_o` is 0 and `sel_idx_o` is 0 (the nominal level).
- R2: The predicted loss is c0 + c1·latency + c2·intensity + c3·stall. Each coefficient is two's complement, COEF_W bits wide. In `coef_i`, c0 occupies bits [COEF_W-1:0], c1 the next COEF_W bits, then c2, then c3. Latency, intensity and stall are unsigned. Level i's latency is `lat_tbl_i[i*LAT_W +: LAT_W]`, and application j's intensity and stall are at `[j*STAT_W +: STAT_W]` of `mpki_i` and `stall_i`.
- R3: The full-precision sum is saturated to a signed LOSS_W-bit value, clamping to the largest or smallest representable value. An application passes when this value is less than or equal to the signed `target_i`.
- R4: A level is accepted only if every one of the NUM_APP applications passes at it.
- R5: Levels are scanned in ascending index order (descending voltage) starting at index 1. The scan stops at the first rejected level, and levels beyond it are not examined. The result is the last accepted index, or NUM_LVL-1 if all levels are accepted.
- R6: If level 1 is rejected, `sel_idx_o` is 0.
- R7: `done_o` is high for exactly one cycle. If the start pulse is sampled at clock edge k, then `done_o` rises after edge k+E, where E counts the evaluation cycles. E is (NUM_LVL-1)·NUM_APP when every level is accepted. When application a (0-based) fails at level j, E is (j-1)·NUM_APP + a + 1.
- R8: `start_i` is ignored while a scan is in progress. `sel_idx_o` changes only on the cycle `done_o` is high, and holds its value between scans whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that launches a scan |
| target_i | input | LOSS_W | Signed loss bound |
| coef_i | input | 4*COEF_W | Packed signed coefficients c0..c3 |
| lat_tbl_i | input | NUM_LVL*LAT_W | Latency of each candidate level |
| mpki_i | input | NUM_APP*STAT_W | Memory intensity per application |
| stall_i | input | NUM_APP*STAT_W | Memory stall time per application |
| sel_idx_o | output | LVL_W | Chosen level index |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The bench walks loss predictions that saturate in both directions against bounds one step apart. A design that wraps instead of clamping would accept or reject the wrong level. Cases where only one application, or only the stall term with a negative coefficient, decides the outcome would expose a design that checks a single application or mis-places a coefficient field. The completion cycle is measured for early rejects, full acceptance and a rejection on the first lowered level. A scan that continued past a failure, or started at the nominal level, would shift both the result and the timing. A second start during a scan and input changes after completion would reveal a selector that restarts or whose result drifts.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_DONE = 2'd2
    } vsel_state_e;

    localparam int NUM_TERMS = 3;
endpackage

// File: rtl/vsel_term.sv
module vsel_term #(
    parameter int COEF_W = 16,
    parameter int OPD_W  = 10,
    localparam int PROD_W = COEF_W + OPD_W + 1
) (
    input  logic signed [COEF_W-1:0] coef_i,
    input  logic        [OPD_W-1:0]  opd_i,
    output logic signed [PROD_W-1:0] prod_o
);
    logic signed [PROD_W-1:0] coef_ext;
    logic signed [PROD_W-1:0] opd_ext;

    always_comb begin
        coef_ext = {{(PROD_W-COEF_W){coef_i[COEF_W-1]}}, coef_i};
        opd_ext  = {{(PROD_W-OPD_W){1'b0}}, opd_i};
        prod_o   = coef_ext * opd_ext;
    end
endmodule

// File: rtl/vsel_loss.sv
module vsel_loss
    import vsel_pkg::*;
#(
    parameter int COEF_W = 16,
    parameter int LAT_W  = 8,
    parameter int STAT_W = 10,
    parameter int LOSS_W = 16
) (
    input  logic [4*COEF_W-1:0]      coef_i,
    input  logic [LAT_W-1:0]         lat_i,
    input  logic [STAT_W-1:0]        mpki_i,
    input  logic [STAT_W-1:0]        stall_i,
    output logic signed [LOSS_W-1:0] loss_o
);
    localparam int OPD_W  = (LAT_W > STAT_W) ? LAT_W : STAT_W;
    localparam int PROD_W = COEF_W + OPD_W + 1;
    localparam int SUM_W  = PROD_W + 2;
    localparam logic signed [SUM_W-1:0] MAX_V =
        {{(SUM_W-LOSS_W+1){1'b0}}, {(LOSS_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] MIN_V =
        {{(SUM_W-LOSS_W+1){1'b1}}, {(LOSS_W-1){1'b0}}};

    logic        [OPD_W-1:0]  opd  [NUM_TERMS];
    logic signed [PROD_W-1:0] prod [NUM_TERMS];
    logic signed [COEF_W-1:0] bias;
    logic signed [SUM_W-1:0]  sum;

    assign opd[0] = OPD_W'(lat_i);
    assign opd[1] = OPD_W'(mpki_i);
    assign opd[2] = OPD_W'(stall_i);
    assign bias   = coef_i[COEF_W-1:0];

    for (genvar g = 0; g < NUM_TERMS; g++) begin : g_term
        vsel_term #(
            .COEF_W(COEF_W),
            .OPD_W (OPD_W)
        ) u_term (
            .coef_i(coef_i[(g+1)*COEF_W +: COEF_W]),
            .opd_i (opd[g]),
            .prod_o(prod[g])
        );
    end

    always_comb begin
        sum = {{(SUM_W-COEF_W){bias[COEF_W-1]}}, bias};
        for (int t = 0; t < NUM_TERMS; t++) begin
            sum = sum + {{(SUM_W-PROD_W){prod[t][PROD_W-1]}}, prod[t]};
        end
        if (sum > MAX_V) begin
            loss_o = MAX_V[LOSS_W-1:0];
        end else if (sum < MIN_V) begin
            loss_o = MIN_V[LOSS_W-1:0];
        end else begin
            loss_o = sum[LOSS_W-1:0];
        end
    end
endmodule

// File: rtl/vsel_ctrl.sv
module vsel_ctrl
    import vsel_pkg::*;
#(
    parameter int NUM_LVL = 8,
    parameter int NUM_APP = 4,
    localparam int LVL_W = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1,
    localparam int APP_W = (NUM_APP > 1) ? $clog2(NUM_APP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             pass_i,
    output logic [LVL_W-1:0] lvl_o,
    output logic [APP_W-1:0] app_o,
    output logic [LVL_W-1:0] sel_o,
    output logic             done_o
);
    vsel_state_e      state_q, state_d;
    logic [LVL_W-1:0] lvl_q, best_q, sel_q;
    logic [APP_W-1:0] app_q;
    logic             app_last, lvl_last;

    assign app_last = (int'(app_q) == NUM_APP - 1);
    assign lvl_last = (int'(lvl_q) == NUM_LVL - 1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_EVAL;
            ST_EVAL: if (!pass_i || (app_last && lvl_last)) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            app_q  <= '0;
            best_q <= '0;
            sel_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        lvl_q  <= LVL_W'(1);
                        app_q  <= '0;
                        best_q <= '0;
                    end
                end
                ST_EVAL: begin
                    if (!pass_i) begin
                        sel_q <= best_q;
                    end else if (app_last) begin
                        best_q <= lvl_q;
                        app_q  <= '0;
                        if (lvl_last) begin
                            sel_q <= lvl_q;
                        end else begin
                            lvl_q <= lvl_q + LVL_W'(1);
                        end
                    end else begin
                        app_q <= app_q + APP_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        lvl_o  = lvl_q;
        app_o  = app_q;
        sel_o  = sel_q;
        done_o = (state_q == ST_DONE);
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_o) |-> done_o);

    // R5
    stop_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL && !pass_i) |=> (done_o && sel_o == $past(best_q)));

    // R5
    lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL) |-> (lvl_q != '0 && int'(lvl_q) < NUM_LVL));

    // R4
    accept_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_EVAL && !$stable(best_q))
            |-> ($past(pass_i) && int'($past(app_q)) == NUM_APP - 1));
endmodule

// File: rtl/perf_volt_sel.sv
module perf_volt_sel
    import vsel_pkg::*;
#(
    parameter int NUM_LVL = 8,
    parameter int NUM_APP = 4,
    parameter int LAT_W   = 8,
    parameter int STAT_W  = 10,
    parameter int COEF_W  = 16,
    parameter int LOSS_W  = 16,
    localparam int LVL_W = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic signed [LOSS_W-1:0]  target_i,
    input  logic [4*COEF_W-1:0]       coef_i,
    input  logic [NUM_LVL*LAT_W-1:0]  lat_tbl_i,
    input  logic [NUM_APP*STAT_W-1:0] mpki_i,
    input  logic [NUM_APP*STAT_W-1:0] stall_i,
    output logic [LVL_W-1:0]          sel_idx_o,
    output logic                      done_o
);
    localparam int APP_W = (NUM_APP > 1) ? $clog2(NUM_APP) : 1;

    logic [LVL_W-1:0]         lvl;
    logic [APP_W-1:0]         app;
    logic [LAT_W-1:0]         cur_lat;
    logic [STAT_W-1:0]        cur_mpki, cur_stall;
    logic signed [LOSS_W-1:0] loss;
    logic                     pass;

    assign cur_lat   = lat_tbl_i[lvl*LAT_W +: LAT_W];
    assign cur_mpki  = mpki_i[app*STAT_W +: STAT_W];
    assign cur_stall = stall_i[app*STAT_W +: STAT_W];
    assign pass      = (loss <= target_i);

    vsel_loss #(
        .COEF_W(COEF_W),
        .LAT_W (LAT_W),
        .STAT_W(STAT_W),
        .LOSS_W(LOSS_W)
    ) u_loss (
        .coef_i (coef_i),
        .lat_i  (cur_lat),
        .mpki_i (cur_mpki),
        .stall_i(cur_stall),
        .loss_o (loss)
    );

    vsel_ctrl #(
        .NUM_LVL(NUM_LVL),
        .NUM_APP(NUM_APP)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .pass_i (pass),
        .lvl_o  (lvl),
        .app_o  (app),
        .sel_o  (sel_idx_o),
        .done_o (done_o)
    );
endmodule

// File: tb/perf_volt_sel_test.sv
`timescale 1ns/1ps
module perf_volt_sel_test;
    localparam int NL = 8;
    localparam int NA = 4;

    typedef struct packed {
        logic signed [15:0] tgt;
        logic signed [15:0] c0;
        logic signed [15:0] c1;
        logic signed [15:0] c2;
        logic signed [15:0] c3;
        logic [9:0] m0, m1, m2, m3;
        logic [9:0] s0, s1, s2, s3;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{16'sd100, 16'sd0, 16'sd1, 16'sd0, 16'sd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0},
        '{16'sd40, 16'sd0, 16'sd1, 16'sd0, 16'sd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0},
        '{16'sd25, 16'sd0, 16'sd1, 16'sd0, 16'sd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0},
        '{16'sd100, 16'sd0, 16'sd1, 16'sd2, 16'sd0, 10'd0, 10'd5, 10'd10, 10'd20, 10'd0, 10'd0, 10'd0, 10'd0},
        '{16'sd60, 16'sd0, 16'sd2, 16'sd0, -16'sd1, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd10},
        '{16'sd32767, 16'sd0, 16'sd0, 16'sd30000, 16'sd0, 10'd1023, 10'd1023, 10'd1023, 10'd1023, 10'd0, 10'd0, 10'd0, 10'd0},
        '{16'sd32766, 16'sd0, 16'sd0, 16'sd30000, 16'sd0, 10'd1023, 10'd1023, 10'd1023, 10'd1023, 10'd0, 10'd0, 10'd0, 10'd0},
        '{16'sh8000, 16'sd0, 16'sd0, -16'sd30000, 16'sd0, 10'd1023, 10'd1023, 10'd1023, 10'd1023, 10'd0, 10'd0, 10'd0, 10'd0},
        '{16'sd49, 16'sd50, 16'sd0, 16'sd0, 16'sd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0},
        '{16'sd50, 16'sd50, 16'sd0, 16'sd0, 16'sd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0},
        '{16'sd100, 16'sd0, 16'sd1, 16'sd0, 16'sd3, 10'd0, 10'd0, 10'd0, 10'd0, 10'd5, 10'd10, 10'd15, 10'd12}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic signed [15:0] target = '0;
    logic [63:0]        coef = '0;
    logic [NL*8-1:0]    lat_tbl;
    logic [NA*10-1:0]   mpki = '0;
    logic [NA*10-1:0]   stall = '0;
    logic [2:0]         sel_idx;
    logic               done;
    int                 total = 0;
    int                 bad = 0;
    bit                 finished = 0;

    always #10 clk = ~clk;

    perf_volt_sel uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .target_i (target),
        .coef_i   (coef),
        .lat_tbl_i(lat_tbl),
        .mpki_i   (mpki),
        .stall_i  (stall),
        .sel_idx_o(sel_idx),
        .done_o   (done)
    );

    function automatic int lat_of(int i);
        return 20 + 6 * i;
    endfunction

    task automatic check(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic void model(input vec_t v, output int sel, output int ev);
        int m [NA];
        int s [NA];
        longint sum;
        bit ok;
        m = '{int'(v.m0), int'(v.m1), int'(v.m2), int'(v.m3)};
        s = '{int'(v.s0), int'(v.s1), int'(v.s2), int'(v.s3)};
        sel = 0;
        ev = 0;
        for (int l = 1; l < NL; l++) begin
            ok = 1;
            for (int a = 0; a < NA; a++) begin
                ev++;
                sum = longint'(v.c0) + longint'(v.c1) * lat_of(l)
                    + longint'(v.c2) * m[a] + longint'(v.c3) * s[a];
                if (sum > 32767) sum = 32767;
                if (sum < -32768) sum = -32768;
                if (sum > longint'(v.tgt)) begin
                    ok = 0;
                    break;
                end
            end
            if (!ok) break;
            sel = l;
        end
    endfunction

    task automatic apply(input vec_t v);
        target = v.tgt;
        coef   = {v.c3, v.c2, v.c1, v.c0};
        mpki   = {v.m3, v.m2, v.m1, v.m0};
        stall  = {v.s3, v.s2, v.s1, v.s0};
    endtask

    task automatic run_scan(input int restart_at, output int cyc, output int done_cnt);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        done_cnt = 0;
        while (!done && cyc < 5000) begin
            start = (cyc == restart_at);
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        if (done) done_cnt = 1;
        @(negedge clk);
        if (done) done_cnt++;
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int esel, ecyc, cyc, dc;
        logic [2:0] held;
        for (int i = 0; i < NL; i++) lat_tbl[i*8 +: 8] = 8'(lat_of(i));

        // R1: values during and after reset
        repeat (3) @(negedge clk);
        check("R1 done in reset", done, 0);
        check("R1 sel in reset", sel_idx, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", done, 0);
        check("R1 sel after reset", sel_idx, 0);

        // R2 R3 R4 R5 R6 R7: vector table
        for (int v = 0; v < 11; v++) begin
            apply(VECS[v]);
            model(VECS[v], esel, ecyc);
            run_scan(-1, cyc, dc);
            check($sformatf("R5 R2 R3 R4 R6 sel vec%0d", v), sel_idx, esel);
            check($sformatf("R7 latency vec%0d", v), cyc, ecyc);
            check($sformatf("R7 pulse vec%0d", v), dc, 1);
        end

        // R8: result holds while inputs change after completion
        apply(VECS[3]);
        run_scan(-1, cyc, dc);
        held = sel_idx;
        check("R8 setup sel", held, 6);
        apply(VECS[2]);
        repeat (6) @(negedge clk);
        check("R8 sel held", sel_idx, 6);
        check("R8 no done", done, 0);

        // R8: second start during a scan is ignored
        apply(VECS[0]);
        run_scan(5, cyc, dc);
        check("R8 restart latency", cyc, (NL - 1) * NA);
        check("R8 restart single done", dc, 1);
        check("R8 restart sel", sel_idx, 7);
        repeat (NL * NA + 4) @(negedge clk);
        check("R8 no extra done", done, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule